// File: doc/BRIEF.md
# Phase-Steered Up/Down DAC Controller

This block sits between a phase-frequency detector and a parallel DAC that sets an oscillator's tuning voltage. It receives the detector's "reference ahead" (lead) and "reference behind" (lag) pulses. It brings each pulse into the system clock domain and measures its width in clock cycles. It then nudges a DAC code up or down, with a step that depends on how wide the winning pulse was.

Narrow pulses fall inside a programmable dead zone and leave the code alone, so a locked loop stops hunting. Wide pulses move the code by 4 or 16 LSB so that acquisition is fast. Only one correction is made per reference period. A period is delimited by a reference-present strobe. A watchdog on that strobe raises a holdover flag when the reference disappears. While the flag is up, the code is frozen at its last value.

Top module: `phase_dac_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge (synchronous reset), the code loads `reset_code_i` and `holdover_o` clears.
- R2: A lead pulse outside the dead zone raises the code and a lag pulse lowers it. The new code appears after the second rising edge at which the input is sampled low once the pulse has ended.
- R3: A pulse's width is the number of rising edges at which it is sampled high. The measurement saturates at its all-ones value.
- R4: A winning width less than or equal to `dz_thr_i` leaves the code unchanged.
- R5: The step is 1 LSB when the width is above `dz_thr_i` and below `mid_thr_i`. It is 4 LSB when the width is at least `mid_thr_i` and below `high_thr_i`. It is 16 LSB when the width is at least `high_thr_i`.
- R6: The code clamps at 0 and at full scale and never wraps.
- R7: At most one update is made between two reference strobes. Reset opens a period.
- R8: Pulses that overlap form one group, and that group is resolved when its last pulse ends. The longer pulse decides the direction and the step. Equal lead and lag widths cause no update.
- R9: `holdover_o` rises once `holdover_lim_i` rising edges have passed since the last strobe or reset. It is low in the cycle after any strobe.
- R10: While `holdover_o` is high, the code does not change. This includes a group that ends in the same cycle as the strobe that clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lead_i | input | 1 | Detector pulse: reference phase ahead (asynchronous) |
| lag_i | input | 1 | Detector pulse: reference phase behind (asynchronous) |
| ref_stb_i | input | 1 | One-cycle reference-present strobe, synchronous |
| dz_thr_i | input | ERR_W | Dead-zone width threshold |
| mid_thr_i | input | ERR_W | Width from which the step is 4 LSB |
| high_thr_i | input | ERR_W | Width from which the step is 16 LSB |
| holdover_lim_i | input | TMO_W | Cycles without a strobe before holdover |
| reset_code_i | input | CODE_W | Code loaded during reset |
| dac_code_o | output | CODE_W | DAC code |
| holdover_o | output | 1 | Reference missing; code frozen |

## Verification
Two functions can fall in the same cycle: the end of a pulse group, which would move the code, and the arrival of the reference strobe, which both opens a new period and clears holdover. The bench first lets holdover rise. It then ends a wide lead pulse and places the strobe zero to four cycles after that edge, so that one offset makes the two events coincide. A behavioural model compares the code and the flag on every clock. The code must stay frozen whenever the flag was still high at the resolving edge, and the following period must open normally.

// File: rtl/pdac_pkg.sv
package pdac_pkg;
    typedef enum logic [1:0] {
        MOVE_HOLD = 2'd0,
        MOVE_UP   = 2'd1,
        MOVE_DOWN = 2'd2
    } move_e;
endpackage

// File: rtl/pdac_pulse_meter.sv
module pdac_pulse_meter #(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pulse_i,
    output logic             end_o,
    output logic [ERR_W-1:0] width_o,
    output logic             pend_o
);
    localparam logic [ERR_W-1:0] WMAX = {ERR_W{1'b1}};

    typedef struct packed {
        logic             s1;
        logic             s2;
        logic [ERR_W-1:0] cnt;
    } meter_t;

    meter_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pulse_i;
        st_d.s2 = st_q.s1;
        if (st_q.s2) begin
            st_d.cnt = (st_q.cnt == WMAX) ? WMAX : st_q.cnt + 1'b1;
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // pulse resolves on the cycle its synchronised copy is last high
    assign end_o   = st_q.s2 & ~st_q.s1;
    assign width_o = (st_q.cnt == WMAX) ? WMAX : st_q.cnt + 1'b1;
    assign pend_o  = st_q.s1;
endmodule

// File: rtl/pdac_ref_watch.sv
module pdac_ref_watch #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    input  logic [TMO_W-1:0] lim_i,
    output logic             hold_o
);
    localparam logic [TMO_W-1:0] CMAX = {TMO_W{1'b1}};

    typedef struct packed {
        logic [TMO_W-1:0] cnt;
        logic             hold;
    } watch_t;

    watch_t st_d, st_q;
    logic [TMO_W:0] elapsed;

    always_comb begin
        st_d    = st_q;
        elapsed = {1'b0, st_q.cnt} + 1'b1;
        if (stb_i) begin
            st_d.cnt  = '0;
            st_d.hold = 1'b0;
        end else begin
            st_d.cnt = (st_q.cnt == CMAX) ? CMAX : st_q.cnt + 1'b1;
            if (elapsed >= {1'b0, lim_i}) begin
                st_d.hold = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o = st_q.hold;
endmodule

// File: rtl/pdac_stepper.sv
module pdac_stepper
    import pdac_pkg::*;
#(
    parameter int CODE_W    = 10,
    parameter int ERR_W     = 8,
    parameter int STEP_MID  = 4,
    parameter int STEP_HIGH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lead_end_i,
    input  logic [ERR_W-1:0]  lead_w_i,
    input  logic              lead_pend_i,
    input  logic              lag_end_i,
    input  logic [ERR_W-1:0]  lag_w_i,
    input  logic              lag_pend_i,
    input  logic              stb_i,
    input  logic              hold_i,
    input  logic [ERR_W-1:0]  dz_thr_i,
    input  logic [ERR_W-1:0]  mid_thr_i,
    input  logic [ERR_W-1:0]  high_thr_i,
    input  logic [CODE_W-1:0] reset_code_i,
    output logic [CODE_W-1:0] code_o
);
    localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] STEP_M   = CODE_W'(STEP_MID);
    localparam logic [CODE_W-1:0] STEP_H   = CODE_W'(STEP_HIGH);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              used;
        logic [ERR_W-1:0]  grp_lead;
        logic [ERR_W-1:0]  grp_lag;
    } step_t;

    step_t st_d, st_q;

    logic [ERR_W-1:0]  lead_best, lag_best, win;
    logic [CODE_W-1:0] step;
    logic [CODE_W:0]   up_sum;
    logic              finish;
    move_e             move;

    always_comb begin
        st_d = st_q;

        lead_best = (lead_end_i && lead_w_i > st_q.grp_lead) ? lead_w_i : st_q.grp_lead;
        lag_best  = (lag_end_i && lag_w_i > st_q.grp_lag) ? lag_w_i : st_q.grp_lag;
        finish    = (lead_end_i | lag_end_i) & ~lead_pend_i & ~lag_pend_i;
        win       = (lead_best > lag_best) ? lead_best : lag_best;

        if (win <= dz_thr_i) begin
            step = '0;
        end else if (win < mid_thr_i) begin
            step = CODE_W'(1);
        end else if (win < high_thr_i) begin
            step = STEP_M;
        end else begin
            step = STEP_H;
        end

        move = MOVE_HOLD;
        if (finish && !st_q.used && !hold_i && step != '0) begin
            if (lead_best > lag_best) begin
                move = MOVE_UP;
            end else if (lag_best > lead_best) begin
                move = MOVE_DOWN;
            end
        end

        up_sum = {1'b0, st_q.code} + {1'b0, step};
        case (move)
            MOVE_UP:   st_d.code = (up_sum > {1'b0, CODE_MAX}) ? CODE_MAX : up_sum[CODE_W-1:0];
            MOVE_DOWN: st_d.code = (st_q.code < step) ? '0 : st_q.code - step;
            default:   st_d.code = st_q.code;
        endcase

        if (finish) begin
            st_d.used     = 1'b1;
            st_d.grp_lead = '0;
            st_d.grp_lag  = '0;
        end else begin
            st_d.grp_lead = lead_best;
            st_d.grp_lag  = lag_best;
        end

        if (stb_i) begin
            st_d.used = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.code     <= reset_code_i;
            st_q.used     <= 1'b0;
            st_q.grp_lead <= '0;
            st_q.grp_lag  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.code;
endmodule

// File: rtl/phase_dac_ctrl.sv
module phase_dac_ctrl #(
    parameter int CODE_W    = 10,
    parameter int ERR_W     = 8,
    parameter int TMO_W     = 16,
    parameter int STEP_MID  = 4,
    parameter int STEP_HIGH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lead_i,
    input  logic              lag_i,
    input  logic              ref_stb_i,
    input  logic [ERR_W-1:0]  dz_thr_i,
    input  logic [ERR_W-1:0]  mid_thr_i,
    input  logic [ERR_W-1:0]  high_thr_i,
    input  logic [TMO_W-1:0]  holdover_lim_i,
    input  logic [CODE_W-1:0] reset_code_i,
    output logic [CODE_W-1:0] dac_code_o,
    output logic              holdover_o
);
    localparam int N_CH = 2;

    logic [N_CH-1:0]  ch_in;
    logic [N_CH-1:0]  ch_end;
    logic [N_CH-1:0]  ch_pend;
    logic [ERR_W-1:0] ch_w [N_CH];

    // channel 0 = lead, channel 1 = lag
    assign ch_in = {lag_i, lead_i};

    for (genvar g = 0; g < N_CH; g++) begin : g_meter
        pdac_pulse_meter #(.ERR_W(ERR_W)) u_meter (
            .clk     (clk),
            .rst_n   (rst_n),
            .pulse_i (ch_in[g]),
            .end_o   (ch_end[g]),
            .width_o (ch_w[g]),
            .pend_o  (ch_pend[g])
        );
    end

    pdac_ref_watch #(.TMO_W(TMO_W)) u_watch (
        .clk    (clk),
        .rst_n  (rst_n),
        .stb_i  (ref_stb_i),
        .lim_i  (holdover_lim_i),
        .hold_o (holdover_o)
    );

    pdac_stepper #(
        .CODE_W    (CODE_W),
        .ERR_W     (ERR_W),
        .STEP_MID  (STEP_MID),
        .STEP_HIGH (STEP_HIGH)
    ) u_step (
        .clk          (clk),
        .rst_n        (rst_n),
        .lead_end_i   (ch_end[0]),
        .lead_w_i     (ch_w[0]),
        .lead_pend_i  (ch_pend[0]),
        .lag_end_i    (ch_end[1]),
        .lag_w_i      (ch_w[1]),
        .lag_pend_i   (ch_pend[1]),
        .stb_i        (ref_stb_i),
        .hold_i       (holdover_o),
        .dz_thr_i     (dz_thr_i),
        .mid_thr_i    (mid_thr_i),
        .high_thr_i   (high_thr_i),
        .reset_code_i (reset_code_i),
        .code_o       (dac_code_o)
    );
endmodule

// File: rtl/pdac_checks.sv
module pdac_checks #(
    parameter int CODE_W    = 10,
    parameter int STEP_MID  = 4,
    parameter int STEP_HIGH = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ref_stb_i,
    input logic [CODE_W-1:0] reset_code_i,
    input logic [CODE_W-1:0] dac_code_o,
    input logic              holdover_o
);
    localparam logic [CODE_W-1:0] CMAX = {CODE_W{1'b1}};

    logic [CODE_W-1:0] prev_q;
    logic              prev_ok_q;
    logic              hold_prev_q;
    logic [CODE_W-1:0] delta;

    always_ff @(posedge clk) begin
        prev_q      <= dac_code_o;
        prev_ok_q   <= rst_n;
        hold_prev_q <= holdover_o;
    end

    assign delta = (dac_code_o > prev_q) ? dac_code_o - prev_q : prev_q - dac_code_o;

    // R1
    reset_load_chk: assert property (@(posedge clk)
        !rst_n |=> (dac_code_o == $past(reset_code_i)) && !holdover_o);

    // R5
    step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prev_ok_q && dac_code_o != prev_q |->
            delta == CODE_W'(1) || delta == CODE_W'(STEP_MID) || delta == CODE_W'(STEP_HIGH)
            || dac_code_o == CMAX || dac_code_o == '0);

    // R6
    no_wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prev_ok_q && prev_q == CMAX |-> dac_code_o >= CMAX - CODE_W'(STEP_HIGH));

    // R6
    no_wrap_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prev_ok_q && prev_q == '0 |-> dac_code_o <= CODE_W'(STEP_HIGH));

    // R9
    strobe_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_stb_i |=> !holdover_o);

    // R10
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prev_ok_q && hold_prev_q |-> dac_code_o == prev_q);
endmodule

bind phase_dac_ctrl pdac_checks #(
    .CODE_W    (CODE_W),
    .STEP_MID  (STEP_MID),
    .STEP_HIGH (STEP_HIGH)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_stb_i    (ref_stb_i),
    .reset_code_i (reset_code_i),
    .dac_code_o   (dac_code_o),
    .holdover_o   (holdover_o)
);

// File: tb/phase_dac_ctrl_tb.sv
module phase_dac_ctrl_tb;
    localparam int CW  = 10;
    localparam int EW  = 8;
    localparam int TW  = 16;
    localparam int DZ  = 2;
    localparam int MID = 6;
    localparam int HI  = 12;
    localparam int LIM = 60;
    localparam int CMAXV = (1 << CW) - 1;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          lead = 1'b0, lag = 1'b0, stb = 1'b0;
    logic [CW-1:0] rc = CW'(512);
    logic [CW-1:0] dac;
    logic          hold;

    phase_dac_ctrl u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .lead_i         (lead),
        .lag_i          (lag),
        .ref_stb_i      (stb),
        .dz_thr_i       (EW'(DZ)),
        .mid_thr_i      (EW'(MID)),
        .high_thr_i     (EW'(HI)),
        .holdover_lim_i (TW'(LIM)),
        .reset_code_i   (rc),
        .dac_code_o     (dac),
        .holdover_o     (hold)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    string req_tag = "R1";
    bit started = 0;

    // behavioural reference
    int mc, mhold, mcnt, mused, l1, l2, g1, g2, lc, gc, bl, bg;
    int le, ge, lw, gw, fin, bestl, bestg, w, st;

    always @(posedge clk) begin
        started = 1;
        if (!rst_n) begin
            mc = int'(rc); mhold = 0; mcnt = 0; mused = 0;
            l1 = 0; l2 = 0; g1 = 0; g2 = 0; lc = 0; gc = 0; bl = 0; bg = 0;
        end else begin
            le = (l2 && !l1) ? 1 : 0;
            ge = (g2 && !g1) ? 1 : 0;
            lw = lc + 1; gw = gc + 1;
            bestl = (le && lw > bl) ? lw : bl;
            bestg = (ge && gw > bg) ? gw : bg;
            fin = ((le || ge) && !l1 && !g1) ? 1 : 0;
            if (fin) begin
                if (!mused && !mhold && bestl != bestg) begin
                    w  = (bestl > bestg) ? bestl : bestg;
                    st = (w <= DZ) ? 0 : (w < MID) ? 1 : (w < HI) ? 4 : 16;
                    if (bestl > bestg) mc = (mc + st > CMAXV) ? CMAXV : mc + st;
                    else               mc = (mc - st < 0) ? 0 : mc - st;
                end
                mused = 1; bl = 0; bg = 0;
            end else begin
                bl = bestl; bg = bestg;
            end
            if (stb) begin
                mused = 0; mcnt = 0; mhold = 0;
            end else begin
                if (mcnt + 1 >= LIM) mhold = 1;
                mcnt++;
            end
            lc = l2 ? lc + 1 : 0;
            gc = g2 ? gc + 1 : 0;
            l2 = l1; l1 = int'(lead);
            g2 = g1; g1 = int'(lag);
        end
    end

    task automatic summary_end();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // per-clock comparison plus watchdog
    always @(negedge clk) begin
        cyc++;
        if (started) begin
            n_cmp++;
            if (int'(dac) != mc || int'(hold) != mhold) begin
                n_bad++;
                $display("FAIL %s cycle %0d actual code=%0d hold=%0d expected code=%0d hold=%0d",
                         req_tag, cyc, dac, hold, mc, mhold);
            end
        end
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            summary_end();
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe();
        @(negedge clk); stb = 1'b1;
        @(negedge clk); stb = 1'b0;
    endtask

    task automatic pulse2(input int lwid, input int gwid);
        int top;
        top = (lwid > gwid) ? lwid : gwid;
        @(negedge clk);
        lead = (lwid > 0); lag = (gwid > 0);
        for (int k = 1; k <= top; k++) begin
            @(negedge clk);
            if (k == lwid) lead = 1'b0;
            if (k == gwid) lag = 1'b0;
        end
        tick(5);
    endtask

    task automatic expect_code(input int exp_c, input string tag);
        n_cmp++;
        if (int'(dac) != exp_c) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, dac, exp_c);
        end
    endtask

    task automatic expect_hold(input int exp_h, input string tag);
        n_cmp++;
        if (int'(hold) != exp_h) begin
            n_bad++;
            $display("FAIL %s holdover actual=%0d expected=%0d", tag, hold, exp_h);
        end
    endtask

    task automatic do_reset(input int code);
        @(negedge clk); rst_n = 1'b0; rc = CW'(code);
        tick(2);
        rst_n = 1'b1;
    endtask

    initial begin
        req_tag = "R1";
        tick(3);
        expect_code(512, "R1"); expect_hold(0, "R1");
        rst_n = 1'b1;

        req_tag = "R2";
        strobe(); pulse2(4, 0);  expect_code(513, "R2/R3/R5 lead 4");
        req_tag = "R4";
        strobe(); pulse2(0, 2);  expect_code(513, "R4 dead zone");
        req_tag = "R5";
        strobe(); pulse2(8, 0);  expect_code(517, "R5 mid step");
        strobe(); pulse2(12, 0); expect_code(533, "R5 high step");
        strobe(); pulse2(0, 7);  expect_code(529, "R2 lag mid step");
        req_tag = "R7";
        pulse2(5, 0);            expect_code(529, "R7 second in period");
        req_tag = "R8";
        strobe(); pulse2(10, 4); expect_code(533, "R8 lead longer");
        strobe(); pulse2(6, 6);  expect_code(533, "R8 tie");
        strobe(); pulse2(3, 9);  expect_code(529, "R8 lag longer");

        req_tag = "R6";
        do_reset(1020);
        strobe(); pulse2(20, 0); expect_code(CMAXV, "R6 top clamp");
        strobe(); pulse2(3, 0);  expect_code(CMAXV, "R6 stay top");
        do_reset(3);
        strobe(); pulse2(0, 20); expect_code(0, "R6 bottom clamp");

        req_tag = "R9";
        do_reset(512);
        tick(LIM + 5);           expect_hold(1, "R9 timeout");
        req_tag = "R10";
        pulse2(8, 0);            expect_code(512, "R10 frozen");
        req_tag = "R9";
        strobe();                expect_hold(0, "R9 strobe clears");

        req_tag = "R10";
        for (int k = 0; k < 5; k++) begin
            tick(LIM + 5);
            @(negedge clk); lead = 1'b1;
            tick(8); lead = 1'b0;
            tick(k);
            strobe();
            tick(5);
        end
        strobe(); pulse2(8, 0);
        tick(3);
        summary_end();
    end
endmodule